// File: doc/BRIEF.md
# Periodic Interrupt Timer Controller

This block counts down a programmable modulus, one step per `tick` pulse, and raises an interrupt request each time the count runs out. A 16-bit control register holds a 3-bit priority level and an 8-bit vector number. A second register holds the modulus. Writing the modulus reloads the counter. After each expiry the counter reloads from the modulus without any action from software. A modulus of zero freezes the counter.

An expiry that occurs while the level is non-zero sets a pending flag. The flag holds the request until it is acknowledged. The block compares its own request with an external request level and drives the higher of the two on `irq_level`. On a tie, the timer's request is the one presented. When `irq_ack` arrives while the timer holds the presented request, the pending flag clears and the vector is returned on `vec_out`, with `vec_valid` high. If the external source holds the request, `vec_valid` stays low and the timer's request stays pending.

A level of zero disables requests, but the counter keeps running. A later non-zero level therefore takes effect on the next expiry of the current count, not on a fresh count.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, the control register reads 0x000F (level 0, vector 0x0F), the modulus reads 0, `irq_level` is 0 and `vec_valid` is 0.
- R2: With `reg_sel`=0, the port addresses the control register: level in bits 10:8, vector in bits 7:0, and bits 15:11 always read zero. Writes are accepted at any time. With `reg_sel`=1, the port addresses the modulus in bits 7:0, and the upper bits read zero.
- R3: Writing a non-zero modulus M loads the counter. The first expiry comes on the M-th `tick` after the write. Later expiries come every M ticks, with no further write needed.
- R4: While the modulus is zero, no expiry occurs, however many ticks arrive.
- R5: With level 0, an expiry creates no request. The counter keeps counting, so a level set later fires at the next expiry of the count already under way.
- R6: An expiry with a non-zero level sets a pending flag. The programmed level then appears on `irq_level` from the cycle after the tick and stays there until the request is acknowledged.
- R7: `irq_level` is the larger of the timer's pending level and `ext_level`. When the two are equal, the timer's request is the one presented.
- R8: `irq_ack` while the timer's request is presented clears the pending flag. On the next cycle, `vec_valid` is 1 and `vec_out` holds the vector. `irq_ack` while the external request is presented leaves `vec_valid` at 0 and keeps the timer's request pending.
- R9: `irq_level` is 0 when no timer request is pending and `ext_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = modulus register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| tick | input | 1 | Count enable pulse from the prescaler |
| ext_level | input | 3 | Level of the competing external request |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_level | output | 3 | Level of the winning request, 0 if none |
| vec_out | output | 8 | Vector returned on a timer acknowledge |
| vec_valid | output | 1 | High for one cycle when `vec_out` is valid |

## Verification
Inputs change at the falling edge, and the bench samples results at a later falling edge.

| Result | When it is due | When the bench samples it |
|---|---|---|
| Register write, seen on `reg_rdata` | After the one rising edge that captures it | Falling edge after the write strobe drops |
| Expiry, seen on `irq_level` | After the rising edge that consumes the tick | Falling edge after that tick |
| Change of `ext_level`, seen on `irq_level` | Combinationally, with no edge between | Same falling edge as the change |
| Acknowledge, seen on `vec_valid`/`vec_out` | One edge later | Falling edge after the acknowledge |

The modulus sweep counts ticks after each load. Before the M-th tick it expects no request; right after that tick it expects the level.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_TMR = 1'b1
   } pit_src_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs #(
   parameter int DATA_W  = 16,
   parameter int LVL_W   = 3,
   parameter int VEC_W   = 8,
   parameter int MOD_W   = 8,
   parameter int VEC_RST = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic [VEC_W-1:0]  vector,
   output logic [MOD_W-1:0]  modulus,
   output logic              mod_load
);
   localparam int CTL_USED = LVL_W + VEC_W;

   assign mod_load = wr & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level   <= '0;
         vector  <= VEC_W'(VEC_RST);
         modulus <= '0;
      end else if (wr) begin
         if (sel) begin
            modulus <= wdata[MOD_W-1:0];
         end else begin
            level  <= wdata[VEC_W +: LVL_W];
            vector <= wdata[VEC_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         rdata[MOD_W-1:0] = modulus;
      end else begin
         rdata[CTL_USED-1:0] = {level, vector};
      end
   end

   // R2
   ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel) |=> (level == $past(wdata[VEC_W +: LVL_W])) && (vector == $past(wdata[VEC_W-1:0])));

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> (rdata[DATA_W-1:CTL_USED] == '0));
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [MOD_W-1:0] load_val,
   input  logic [MOD_W-1:0] modulus,
   output logic             expire
);
   logic [MOD_W-1:0] cnt;
   logic             run;

   assign run    = tick && !load && (modulus != '0);
   assign expire = run && (cnt <= MOD_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (run) begin
         cnt <= expire ? modulus : cnt - MOD_W'(1);
      end
   end

   // R4
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (modulus == '0 && !load) |=> $stable(cnt));

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && modulus != '0 && cnt > MOD_W'(1)) |=> (cnt == $past(cnt) - MOD_W'(1)));

   // R3
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(modulus)));
endmodule

// File: rtl/pit_arb.sv
module pit_arb
   import pit_pkg::*;
#(
   parameter int LVL_W   = 3,
   parameter int VEC_W   = 8,
   parameter bit VEC_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic [LVL_W-1:0] level,
   input  logic [VEC_W-1:0] vector,
   input  logic [LVL_W-1:0] ext_level,
   input  logic             ack,
   output logic [LVL_W-1:0] irq_level,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid
);
   logic             pend;
   logic             set_p;
   logic             tmr_ack;
   logic [LVL_W-1:0] tmr_lvl;
   pit_src_e         src;

   assign set_p   = expire && (level != '0);
   assign tmr_lvl = pend ? level : '0;
   assign src     = ((tmr_lvl != '0) && (tmr_lvl >= ext_level)) ? SRC_TMR : SRC_EXT;
   assign tmr_ack = ack && (src == SRC_TMR);
   assign irq_level = (src == SRC_TMR) ? tmr_lvl : ext_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else begin
         pend <= (pend && !tmr_ack) || set_p;
      end
   end

   generate
      if (VEC_REG) begin : g_vec_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_valid <= 1'b0;
               vec_out   <= '0;
            end else begin
               vec_valid <= tmr_ack;
               vec_out   <= tmr_ack ? vector : '0;
            end
         end

         // R8
         vec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && pend && level != '0 && level >= ext_level) |=> (vec_valid && vec_out == $past(vector)));
      end else begin : g_vec_comb
         assign vec_valid = tmr_ack;
         assign vec_out   = tmr_ack ? vector : '0;
      end
   endgenerate

   // R7
   tie_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && level != '0 && level >= ext_level) |-> (irq_level == level));

   // R7
   max_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level >= ext_level);

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && pend && level != '0 && level >= ext_level && !expire) |=> !pend);

   // R8
   keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && ext_level > level) |=> pend);

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && ext_level == '0) |-> (irq_level == '0));
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
   parameter int DATA_W  = 16,
   parameter int LVL_W   = 3,
   parameter int VEC_W   = 8,
   parameter int MOD_W   = 8,
   parameter int VEC_RST = 15,
   parameter bit VEC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick,
   input  logic [LVL_W-1:0]  ext_level,
   input  logic              irq_ack,
   output logic [LVL_W-1:0]  irq_level,
   output logic [VEC_W-1:0]  vec_out,
   output logic              vec_valid
);
   generate
      if (DATA_W < LVL_W + VEC_W) begin : g_bad_ctl
         $error("control fields do not fit in DATA_W");
      end
      if (MOD_W > DATA_W || MOD_W < 1) begin : g_bad_mod
         $error("MOD_W must lie in 1..DATA_W");
      end
      if (VEC_RST >= (1 << VEC_W)) begin : g_bad_rst
         $error("VEC_RST does not fit in VEC_W");
      end
   endgenerate

   logic [LVL_W-1:0] level;
   logic [VEC_W-1:0] vector;
   logic [MOD_W-1:0] modulus;
   logic             mod_load;
   logic             expire;

   pit_regs #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .MOD_W(MOD_W), .VEC_RST(VEC_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .rdata(reg_rdata), .level(level), .vector(vector), .modulus(modulus),
      .mod_load(mod_load)
   );

   pit_counter #(.MOD_W(MOD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(mod_load),
      .load_val(reg_wdata[MOD_W-1:0]), .modulus(modulus), .expire(expire)
   );

   pit_arb #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_REG(VEC_REG)) u_arb (
      .clk(clk), .rst_n(rst_n), .expire(expire), .level(level), .vector(vector),
      .ext_level(ext_level), .ack(irq_ack), .irq_level(irq_level),
      .vec_out(vec_out), .vec_valid(vec_valid)
   );
endmodule

// File: tb/tb_periodic_irq_timer.sv
module tb_periodic_irq_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tick = 1'b0;
   logic [2:0]  ext_level = '0;
   logic        irq_ack = 1'b0;
   logic [2:0]  irq_level;
   logic [7:0]  vec_out;
   logic        vec_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   periodic_irq_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
      .ext_level(ext_level), .irq_ack(irq_ack), .irq_level(irq_level),
      .vec_out(vec_out), .vec_valid(vec_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input bit sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input bit sel, output logic [15:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(1'b0, rd);
      check(rd == 16'h000F, "R1 control", rd, 16'h000F);
      rd_reg(1'b1, rd);
      check(rd == 16'h0000, "R1 modulus", rd, 0);
      check(irq_level == 0, "R1 irq_level", irq_level, 0);
      check(vec_valid == 0, "R1 vec_valid", vec_valid, 0);

      // R2 reserved bits and layout
      wr_reg(1'b0, 16'hFFFF);
      rd_reg(1'b0, rd);
      check(rd == 16'h07FF, "R2 reserved", rd, 16'h07FF);
      wr_reg(1'b1, 16'hFFA5);
      rd_reg(1'b1, rd);
      check(rd == 16'h00A5, "R2 modulus", rd, 16'h00A5);

      // R4 zero modulus halts
      wr_reg(1'b0, 16'h0333);
      wr_reg(1'b1, 16'h0000);
      for (int i = 0; i < 12; i++) do_tick();
      check(irq_level == 0, "R4 halted", irq_level, 0);

      // R3 R6 R8 sweep over modulus and level
      for (int m = 1; m <= 6; m++) begin
         int lv;
         int vc;
         lv = (m % 7) + 1;
         vc = 8'h40 + m;
         wr_reg(1'b0, 16'((lv << 8) | vc));
         wr_reg(1'b1, 16'(m));
         for (int k = 1; k <= m; k++) begin
            do_tick();
            check(irq_level == ((k == m) ? lv : 0), "R3 expiry tick", irq_level, (k == m) ? lv : 0);
         end
         do_tick();
         check(irq_level == lv, "R6 held until ack", irq_level, lv);
         do_ack();
         check(vec_valid == 1 && vec_out == vc, "R8 vector", vec_out, vc);
         check(irq_level == 0, "R9 cleared", irq_level, 0);
         // R3 reload: one tick consumed above, so m-1 more finish the second period
         for (int k = 2; k <= m; k++) begin
            check(irq_level == 0, "R3 before reload expiry", irq_level, 0);
            do_tick();
         end
         if (m == 1) do_tick();
         check(irq_level == lv, "R3 periodic reload", irq_level, lv);
         do_ack();
      end

      // R5 disabled level: no request, counter keeps running
      wr_reg(1'b0, 16'h0012);
      wr_reg(1'b1, 16'h0002);
      do_tick(); do_tick();
      check(irq_level == 0, "R5 no request", irq_level, 0);
      wr_reg(1'b0, 16'h0512);
      check(irq_level == 0, "R5 no stored request", irq_level, 0);
      wr_reg(1'b0, 16'h0012);
      wr_reg(1'b1, 16'h0004);
      do_tick(); do_tick(); do_tick();
      wr_reg(1'b0, 16'h0512);
      check(irq_level == 0, "R5 mid count", irq_level, 0);
      do_tick();
      check(irq_level == 5, "R5 count continued", irq_level, 5);
      do_ack();

      // R7 tie: timer wins
      wr_reg(1'b0, 16'h045A);
      wr_reg(1'b1, 16'h0002);
      do_tick(); do_tick();
      @(negedge clk);
      ext_level = 3'd4;
      #1 check(irq_level == 4, "R7 tie level", irq_level, 4);
      do_ack();
      check(vec_valid == 1 && vec_out == 8'h5A, "R7 tie timer serviced", vec_out, 8'h5A);
      check(irq_level == 4, "R7 external after", irq_level, 4);
      do_ack();
      check(vec_valid == 0, "R8 external ack", vec_valid, 0);

      // R7 R8 external higher
      @(negedge clk);
      ext_level = 3'd6;
      do_tick(); do_tick();
      check(irq_level == 6, "R7 external higher", irq_level, 6);
      do_ack();
      check(vec_valid == 0, "R8 no vector on external", vec_valid, 0);
      @(negedge clk);
      ext_level = 3'd0;
      #1 check(irq_level == 4, "R8 timer still pending", irq_level, 4);
      @(negedge clk);
      ext_level = 3'd2;
      #1 check(irq_level == 4, "R7 timer higher", irq_level, 4);
      do_ack();
      check(vec_valid == 1 && vec_out == 8'h5A, "R8 late vector", vec_out, 8'h5A);
      @(negedge clk);
      ext_level = 3'd0;
      #1 check(irq_level == 0, "R9 idle", irq_level, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule